// File: doc/BRIEF.md
# Range-Matched Translation Cache

This block is a small, fully associative cache of address mappings. Each entry maps one naturally aligned region of virtual address space to a physical base. The region size is a power of two, given as a log2 exponent. A region may also be marked global. Because every entry carries its own size, small and large pages sit side by side in the same array. A lookup compares the incoming virtual address against every valid entry in parallel. One cycle later it reports whether there was a hit, which entry matched and the physical address.

The cache tracks the recency of every entry as a rank, where 0 is the most recently used. When all entries are occupied, new mappings replace the least recently used one. The caller can make a lookup either promote its hit to most recently used or leave the order alone, as a speculative probe would. Three maintenance commands are provided: a flush that empties the whole cache, a flush that spares global entries, and a demap that removes the entry covering a given address.

Top module: `range_tlb`

## Requirements
- R1: After reset every entry is free, and no lookup hits until a mapping has been inserted.
- R2: An entry with base B and size exponent S hits a lookup address V when B <= V < B + 2^S. The outcome appears on `res_hit`/`res_idx`/`res_pa` in the cycle after `lk_en` is high.
- R3: On insert, the low S bits of both the virtual and the physical address are dropped. On a hit, `res_pa` equals the stored physical base ORed with the low S bits of the lookup address.
- R4: An insert takes the free entry with the lowest index when at least one entry is free.
- R5: When no entry is free, an insert overwrites the least recently used entry. The inserted entry becomes the most recently used.
- R6: A hitting lookup with `lk_touch` high makes the matched entry the most recently used. With `lk_touch` low the recency order is unchanged.
- R7: When several valid entries cover the lookup address, the most recently used of them is reported.
- R8: `flush_all` frees every entry.
- R9: `flush_local` frees only the entries whose global flag is clear. Global entries keep their contents and their recency order.
- R10: `demap_en` frees the most recently used entry covering `demap_va`, if there is one, and leaves the recency order unchanged.
- R11: When several commands arrive in one cycle, only the highest-priority one acts. The priority order is flush_all, then flush_local, then demap, then insert, then the recency promotion of a lookup. A lookup always sees the contents from before that cycle's update.
- R12: `res_hit` is low in every cycle that does not follow a cycle with `lk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Write a new mapping |
| ins_va | input | VA_W | Virtual address of the new region |
| ins_szl | input | SZL_W | log2 of the region size |
| ins_pa | input | PA_W | Physical address of the new region |
| ins_global | input | 1 | Region survives `flush_local` |
| lk_en | input | 1 | Perform a lookup |
| lk_va | input | VA_W | Lookup address |
| lk_touch | input | 1 | Promote a hit to most recently used |
| flush_all | input | 1 | Free every entry |
| flush_local | input | 1 | Free every non-global entry |
| demap_en | input | 1 | Free the entry covering `demap_va` |
| demap_va | input | VA_W | Address to demap |
| res_hit | output | 1 | Registered lookup hit |
| res_idx | output | $clog2(N) | Registered index of the matched entry |
| res_pa | output | PA_W | Registered translated address |

## Verification
The hardest state to reach from the ports is the one where several valid entries of different sizes cover the same address and their recency order has been reshuffled by a mix of touching and non-touching lookups. In that state, eviction, demap and overlap resolution must all pick the same "most recent" entry. Directed sequences first build this state on purpose: a large region is inserted over small ones, and a lookup without touch is followed by an eviction. A long random phase then confines addresses to a 16 KiB window with region sizes from 16 bytes to 4 KiB, so overlaps are constant. Every random cycle may raise several commands at once, and a queue-based recency model in the bench predicts each registered output.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

  // Action taken by the cache in a cycle, after priority resolution
  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH_ALL,
    OP_FLUSH_LOCAL,
    OP_DEMAP,
    OP_INSERT,
    OP_TOUCH
  } tlb_op_e;

endpackage

// File: rtl/range_tlb_match.sv
// Range compare of one entry against one address (aligned power-of-two region)
module range_tlb_match #(
  parameter int VA_W  = 32,
  parameter int SZL_W = 5
) (
  input  logic             valid,
  input  logic [VA_W-1:0]  base,
  input  logic [SZL_W-1:0] szl,
  input  logic [VA_W-1:0]  va,
  output logic             hit
);
  logic [VA_W-1:0] low_mask;

  always_comb begin
    low_mask = (VA_W'(1) << szl) - VA_W'(1);
    hit      = valid && (((va ^ base) & ~low_mask) == '0);
  end
endmodule

// File: rtl/range_tlb_pick.sv
// Chooses the matching entry with the lowest recency rank
module range_tlb_pick #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input  logic [N-1:0]    hits,
  input  logic [N*RW-1:0] ranks,
  output logic            any,
  output logic [RW-1:0]   idx
);
  logic [RW-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      if (hits[i] && (!any || ranks[i*RW +: RW] < best)) begin
        any  = 1'b1;
        idx  = RW'(i);
        best = ranks[i*RW +: RW];
      end
    end
  end
endmodule

// File: rtl/range_tlb_rank.sv
// Per-entry recency rank, 0 = most recently used; always a permutation
module range_tlb_rank #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prom_en,
  input  logic [RW-1:0]   prom_idx,
  output logic [N*RW-1:0] ranks
);
  logic [N*RW-1:0] rank_q, rank_n;
  logic [RW-1:0]   prom_rank;

  always_comb begin
    prom_rank = rank_q[prom_idx*RW +: RW];
    rank_n    = rank_q;
    for (int i = 0; i < N; i++) begin
      if (RW'(i) == prom_idx)
        rank_n[i*RW +: RW] = '0;
      else if (rank_q[i*RW +: RW] < prom_rank)
        rank_n[i*RW +: RW] = rank_q[i*RW +: RW] + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i*RW +: RW] <= RW'(i);
    end else if (prom_en) begin
      rank_q <= rank_n;
    end
  end

  assign ranks = rank_q;
endmodule

// File: rtl/range_tlb.sv
module range_tlb #(
  parameter int N     = 4,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int SZL_W = 5,
  localparam int RW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_va,
  input  logic [SZL_W-1:0] ins_szl,
  input  logic [PA_W-1:0]  ins_pa,
  input  logic             ins_global,
  input  logic             lk_en,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_touch,
  input  logic             flush_all,
  input  logic             flush_local,
  input  logic             demap_en,
  input  logic [VA_W-1:0]  demap_va,
  output logic             res_hit,
  output logic [RW-1:0]    res_idx,
  output logic [PA_W-1:0]  res_pa
);
  import range_tlb_pkg::*;

  logic [N-1:0]     vld_q, vld_n, glb_q;
  logic [VA_W-1:0]  vbase_q [N];
  logic [PA_W-1:0]  pbase_q [N];
  logic [SZL_W-1:0] szl_q   [N];
  logic [N*RW-1:0]  rank_flat;

  logic [N-1:0]     lk_hits, dm_hits;
  logic             lk_any, dm_any, free_any;
  logic [RW-1:0]    lk_idx, dm_idx, free_idx, lru_idx, victim;
  logic [PA_W-1:0]  lk_pmask, lk_pa;
  logic [VA_W-1:0]  ins_vmask;
  logic [PA_W-1:0]  ins_pmask;
  logic             wr_en, prom_en;
  logic [RW-1:0]    prom_idx;
  tlb_op_e          op;

  // parallel range compare: one comparator per entry for lookup and demap
  for (genvar g = 0; g < N; g++) begin : g_ent
    range_tlb_match #(.VA_W(VA_W), .SZL_W(SZL_W)) u_lk (
      .valid(vld_q[g]), .base(vbase_q[g]), .szl(szl_q[g]),
      .va(lk_va), .hit(lk_hits[g]));
    range_tlb_match #(.VA_W(VA_W), .SZL_W(SZL_W)) u_dm (
      .valid(vld_q[g]), .base(vbase_q[g]), .szl(szl_q[g]),
      .va(demap_va), .hit(dm_hits[g]));
  end

  range_tlb_pick #(.N(N), .RW(RW)) u_lk_pick (
    .hits(lk_hits), .ranks(rank_flat), .any(lk_any), .idx(lk_idx));
  range_tlb_pick #(.N(N), .RW(RW)) u_dm_pick (
    .hits(dm_hits), .ranks(rank_flat), .any(dm_any), .idx(dm_idx));

  range_tlb_rank #(.N(N), .RW(RW)) u_rank (
    .clk(clk), .rst_n(rst_n), .prom_en(prom_en),
    .prom_idx(prom_idx), .ranks(rank_flat));

  // victim: lowest free entry, else the one holding the oldest rank
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = RW'(i);
      end
    end
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (rank_flat[i*RW +: RW] == RW'(N - 1)) lru_idx = RW'(i);
    end
    victim = free_any ? free_idx : lru_idx;
  end

  // command priority
  always_comb begin
    if (flush_all)                     op = OP_FLUSH_ALL;
    else if (flush_local)              op = OP_FLUSH_LOCAL;
    else if (demap_en)                 op = OP_DEMAP;
    else if (ins_en)                   op = OP_INSERT;
    else if (lk_en && lk_touch && lk_any) op = OP_TOUCH;
    else                               op = OP_NONE;
  end

  // next-state of the valid bits and control of the entry/rank writes
  always_comb begin
    vld_n = vld_q;
    unique case (op)
      OP_FLUSH_ALL:   vld_n = '0;
      OP_FLUSH_LOCAL: vld_n = vld_q & glb_q;
      OP_DEMAP:       if (dm_any) vld_n[dm_idx] = 1'b0;
      OP_INSERT:      vld_n[victim] = 1'b1;
      default:        vld_n = vld_q;
    endcase
    wr_en     = (op == OP_INSERT);
    prom_en   = (op == OP_INSERT) || (op == OP_TOUCH);
    prom_idx  = (op == OP_INSERT) ? victim : lk_idx;
    ins_vmask = (VA_W'(1) << ins_szl) - VA_W'(1);
    ins_pmask = (PA_W'(1) << ins_szl) - PA_W'(1);
    lk_pmask  = (PA_W'(1) << szl_q[lk_idx]) - PA_W'(1);
    lk_pa     = pbase_q[lk_idx] | (PA_W'(lk_va) & lk_pmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vbase_q[victim] <= ins_va & ~ins_vmask;
      pbase_q[victim] <= ins_pa & ~ins_pmask;
      szl_q[victim]   <= ins_szl;
      glb_q[victim]   <= ins_global;
    end
  end

  // registered lookup result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_hit <= 1'b0;
    else        res_hit <= lk_en && lk_any;
  end

  always_ff @(posedge clk) begin
    if (lk_en) begin
      res_idx <= lk_idx;
      res_pa  <= lk_pa;
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_en,
  input logic            lk_en,
  input logic            flush_all,
  input logic            flush_local,
  input logic            demap_en,
  input logic            res_hit,
  input logic [N-1:0]    vld,
  input logic [N-1:0]    glb,
  input logic [N*RW-1:0] ranks
);
  logic [(2**RW)-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) seen[ranks[i*RW +: RW]] = 1'b1;
  end

  // R12
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> !res_hit);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0));

  // R8
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_all) && lk_en) |=> !res_hit);

  // R9
  keep_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all) |=> (vld == ($past(vld) & $past(glb))));

  // R9
  flush_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_local) |=> $stable(ranks));

  // R10
  demap_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demap_en && !flush_all && !flush_local) |=> $stable(ranks));

  // R10
  demap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demap_en && !flush_all && !flush_local) |=>
      (((vld & ~$past(vld)) == '0) && ($countones($past(vld) & ~vld) <= 1)));

  // R4
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !flush_all && !flush_local && !demap_en && !(&vld)) |=>
      ($countones(vld) == $countones($past(vld)) + 1));

  // R5
  rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N);
endmodule

bind range_tlb range_tlb_chk #(.N(N), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .lk_en(lk_en),
  .flush_all(flush_all), .flush_local(flush_local), .demap_en(demap_en),
  .res_hit(res_hit), .vld(vld_q), .glb(glb_q), .ranks(rank_flat));

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;
  localparam int N = 4;

  logic        clk, rst_n;
  logic        ins_en, ins_global, lk_en, lk_touch;
  logic        flush_all, flush_local, demap_en;
  logic [31:0] ins_va, ins_pa, lk_va, demap_va;
  logic [4:0]  ins_szl;
  logic        res_hit;
  logic [1:0]  res_idx;
  logic [31:0] res_pa;

  int nchk = 0;
  int nerr = 0;
  string phase = "R1";

  range_tlb u0 (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_va(ins_va),
    .ins_szl(ins_szl), .ins_pa(ins_pa), .ins_global(ins_global),
    .lk_en(lk_en), .lk_va(lk_va), .lk_touch(lk_touch),
    .flush_all(flush_all), .flush_local(flush_local),
    .demap_en(demap_en), .demap_va(demap_va),
    .res_hit(res_hit), .res_idx(res_idx), .res_pa(res_pa));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit          m_vld [N];
  bit          m_glb [N];
  logic [31:0] m_base [N];
  logic [31:0] m_pbase [N];
  int          m_szl [N];
  int          order[$];          // front = most recently used
  bit          e_hit;
  int          e_idx;
  logic [31:0] e_pa;

  function automatic logic [31:0] lowbits(int s);
    return 32'((64'd1 << s) - 64'd1);
  endfunction

  function automatic int m_find(logic [31:0] va);
    foreach (order[k]) begin
      int i = order[k];
      if (m_vld[i] && longint'(va) >= longint'(m_base[i]) &&
          longint'(va) < longint'(m_base[i]) + (longint'(1) << m_szl[i]))
        return i;
    end
    return -1;
  endfunction

  function automatic void m_front(int i);
    foreach (order[k]) if (order[k] == i) begin order.delete(k); break; end
    order.push_front(i);
  endfunction

  function automatic void m_reset();
    order = {};
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; order.push_back(i); end
    e_hit = 0;
  endfunction

  function automatic void m_step();
    int h, d, v;
    h = m_find(lk_va);
    e_hit = lk_en && (h >= 0);
    if (e_hit) begin
      e_idx = h;
      e_pa  = m_pbase[h] | (lk_va & lowbits(m_szl[h]));
    end
    if (flush_all) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (flush_local) begin
      for (int i = 0; i < N; i++) if (!m_glb[i]) m_vld[i] = 0;
    end else if (demap_en) begin
      d = m_find(demap_va);
      if (d >= 0) m_vld[d] = 0;
    end else if (ins_en) begin
      v = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) v = i;
      if (v < 0) v = order[$];
      m_vld[v] = 1; m_glb[v] = ins_global; m_szl[v] = int'(ins_szl);
      m_base[v]  = ins_va & ~lowbits(int'(ins_szl));
      m_pbase[v] = ins_pa & ~lowbits(int'(ins_szl));
      m_front(v);
    end else if (lk_en && lk_touch && h >= 0) begin
      m_front(h);
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else        m_step();
  end

  // compare with the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      nchk++;
      if (res_hit !== e_hit ||
          (e_hit && (int'(res_idx) != e_idx || res_pa !== e_pa))) begin
        nerr++;
        $display("FAIL %s model: hit=%0b idx=%0d pa=%h expected hit=%0b idx=%0d pa=%h",
                 phase, res_hit, res_idx, res_pa, e_hit, e_idx, e_pa);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    ins_en = 0; ins_global = 0; lk_en = 0; lk_touch = 0;
    flush_all = 0; flush_local = 0; demap_en = 0;
    ins_va = '0; ins_pa = '0; ins_szl = '0; lk_va = '0; demap_va = '0;
  endtask

  task automatic step_end();
    @(negedge clk);
    idle();
  endtask

  task automatic do_ins(logic [31:0] va, int s, logic [31:0] pa, bit g);
    @(negedge clk);
    ins_en = 1; ins_va = va; ins_szl = 5'(s); ins_pa = pa; ins_global = g;
    step_end();
  endtask

  task automatic do_demap(logic [31:0] va);
    @(negedge clk); demap_en = 1; demap_va = va; step_end();
  endtask

  task automatic do_flush(bit all);
    @(negedge clk); flush_all = all; flush_local = !all; step_end();
  endtask

  task automatic expect_res(bit h, int idx, logic [31:0] pa, string tag);
    nchk++;
    if (res_hit !== h || (h && (int'(res_idx) != idx || res_pa !== pa))) begin
      nerr++;
      $display("FAIL %s: hit=%0b idx=%0d pa=%h expected hit=%0b idx=%0d pa=%h",
               tag, res_hit, res_idx, res_pa, h, idx, pa);
    end
  endtask

  task automatic look(logic [31:0] va, bit t, bit h, int idx,
                      logic [31:0] pa, string tag);
    @(negedge clk);
    lk_en = 1; lk_va = va; lk_touch = t;
    step_end();
    expect_res(h, idx, pa, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_res(0, 0, 0, "R1 reset");
    look(32'h0000_1000, 1, 0, 0, 0, "R1 empty");

    phase = "R2";
    do_ins(32'h0000_1000, 12, 32'h8000_0000, 0);      // e0
    do_ins(32'h0002_0000, 16, 32'h4000_0000, 1);      // e1
    do_ins(32'h0000_3123,  8, 32'h7777_7777, 0);      // e2 base 0x3100
    look(32'h0000_1abc, 0, 1, 0, 32'h8000_0abc, "R2 inside");
    look(32'h0000_1fff, 0, 1, 0, 32'h8000_0fff, "R2 top edge");
    look(32'h0000_2000, 0, 0, 0, 0, "R2 just above");
    look(32'h0000_0fff, 0, 0, 0, 0, "R2 just below");
    look(32'h0000_31ff, 0, 1, 2, 32'h7777_77ff, "R3 aligned pbase");
    look(32'h0000_3100, 0, 1, 2, 32'h7777_7700, "R3 aligned base");
    look(32'h0000_3200, 0, 0, 0, 0, "R3 beyond aligned");
    look(32'h0002_abcd, 0, 1, 1, 32'h4000_abcd, "R3 64K page");

    phase = "R4";
    do_ins(32'h0000_5000, 12, 32'h9000_0000, 0);      // e3, order 3 2 1 0
    look(32'h0000_5004, 0, 1, 3, 32'h9000_0004, "R4 lowest free");

    phase = "R6";
    look(32'h0000_1abc, 0, 1, 0, 32'h8000_0abc, "R6 no touch");
    look(32'h0002_0000, 1, 1, 1, 32'h4000_0000, "R6 touch");  // 1 3 2 0
    phase = "R5";
    do_ins(32'h0000_8000, 12, 32'hA000_0000, 0);      // evicts e0
    look(32'h0000_1abc, 0, 0, 0, 0, "R6 untouched entry evicted");
    look(32'h0000_8010, 0, 1, 0, 32'hA000_0010, "R5 reuse LRU");  // 0 1 3 2
    do_ins(32'h0000_9000, 12, 32'hB000_0000, 0);      // evicts e2
    look(32'h0000_3150, 0, 0, 0, 0, "R5 LRU gone");
    do_ins(32'h0000_A000, 12, 32'hC000_0000, 0);      // evicts e3, not e2
    look(32'h0000_9abc, 0, 1, 2, 32'hB000_0abc, "R5 new entry is MRU");
    look(32'h0000_5004, 0, 0, 0, 0, "R5 oldest evicted");  // order 3 2 0 1

    phase = "R7";
    do_ins(32'h0000_8000, 16, 32'hD000_0000, 1);      // evicts e1, base 0
    look(32'h0000_8123, 0, 1, 1, 32'hD000_8123, "R7 MRU overlap");
    phase = "R10";
    do_demap(32'h0000_8123);                          // removes e1
    look(32'h0000_8123, 0, 1, 0, 32'hA000_0123, "R10 demap MRU match");
    look(32'h0000_4000, 0, 0, 0, 0, "R10 demapped region");

    phase = "R9";
    do_ins(32'h0004_0000, 12, 32'hE000_0000, 1);      // e1 global
    do_flush(0);
    look(32'h0004_0010, 0, 1, 1, 32'hE000_0010, "R9 global kept");
    look(32'h0000_9abc, 0, 0, 0, 0, "R9 local freed");
    look(32'h0000_A000, 0, 0, 0, 0, "R9 local freed");
    do_ins(32'h0000_1000, 12, 32'h1000_0000, 0);      // e0
    do_ins(32'h0000_2000, 12, 32'h2000_0000, 0);      // e2
    do_ins(32'h0000_3000, 12, 32'h3000_0000, 0);      // e3
    do_ins(32'h0000_4000, 12, 32'h4000_0000, 0);      // evicts oldest: e1
    look(32'h0004_0010, 0, 0, 0, 0, "R9 global kept its old rank");
    look(32'h0000_4abc, 0, 1, 1, 32'h4000_0abc, "R9 reuse");

    phase = "R8";
    do_flush(1);
    look(32'h0000_1000, 0, 0, 0, 0, "R8 flushed");
    look(32'h0000_4abc, 0, 0, 0, 0, "R8 flushed");
    do_ins(32'h0000_7000, 12, 32'h7000_0000, 0);
    look(32'h0000_7010, 0, 1, 0, 32'h7000_0010, "R8 refill from entry 0");

    phase = "R11";
    @(negedge clk);
    flush_all = 1; ins_en = 1; ins_va = 32'h6000; ins_szl = 5'd12;
    ins_pa = 32'h6000_0000; lk_en = 1; lk_va = 32'h7010;
    step_end();
    expect_res(1, 0, 32'h7000_0010, "R11 lookup sees old state");
    look(32'h0000_6000, 0, 0, 0, 0, "R11 insert lost to flush");
    look(32'h0000_7010, 0, 0, 0, 0, "R11 flush acted");
    do_ins(32'h0000_1000, 12, 32'h1000_0000, 0);
    @(negedge clk);
    demap_en = 1; demap_va = 32'h1000; ins_en = 1; ins_va = 32'h2000;
    ins_szl = 5'd12; ins_pa = 32'h2000_0000;
    step_end();
    look(32'h0000_1000, 0, 0, 0, 0, "R11 demap acted");
    look(32'h0000_2000, 0, 0, 0, 0, "R11 insert lost to demap");
    look(32'h0000_0000, 0, 0, 0, 0, "R12 miss on empty");

    // random phase, model-checked every cycle
    phase = "R11 random";
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      idle();
      flush_all   = ($urandom % 97) == 0;
      flush_local = ($urandom % 41) == 0;
      demap_en    = ($urandom % 7) == 0;
      demap_va    = $urandom % 32'h4000;
      ins_en      = ($urandom % 4) == 0;
      ins_szl     = 5'(4 + $urandom % 9);
      ins_va      = $urandom % 32'h4000;
      ins_pa      = $urandom;
      ins_global  = $urandom % 2;
      lk_en       = ($urandom % 3) != 0;
      lk_touch    = $urandom % 2;
      lk_va       = $urandom % 32'h4000;
    end
    step_end();
    @(negedge clk);
    finish_run();
  end
endmodule